// File: doc/BRIEF.md
# Three-Master Priority Bus Arbiter

This block shares one system bus among three masters. Master 0 is the processor. It is the default owner and never raises a request. Master 1 is a data transfer engine. Master 2 is an Ethernet DMA engine. Priority is fixed and rises with the master index. A requesting master keeps its request high for its whole sequence of transfers. The master gives the bus back by dropping that request.

Ownership moves only at a bus-cycle boundary, which the current owner reports on its cycle-end line. It never moves while the owner's atomic line marks a multi-part access in progress. When the processor is asleep and owns the bus, a pending request is served at once, without waiting for a boundary. Every change of owner passes through one cycle in which no grant is asserted, so two masters never drive the bus together.

Top module: `bus_arb3`

## Requirements
- R1: While `rst` is high, the grant vector settles to 3'b001 at each clock edge, so the processor owns the bus.
- R2: At most one bit of `mst_gnt` is ever high.
- R3: A grant that is high is followed either by the same grant or by a cycle with all grants low. No grant moves directly to another master.
- R4: After a cycle with all grants low, if masters 1 and 2 are not requesting, the processor (bit 0) is granted in the next cycle.
- R5: After a cycle with all grants low, the highest-index requester is granted in the next cycle. Master 2 wins over master 1.
- R6: While the processor owns the bus and `cpu_sleep` is low, its grant is kept unless `mst_cyc_end[0]` is high and `mst_atomic[0]` is low in the same cycle.
- R7: While the processor owns the bus, `cpu_sleep` is high and any request is pending, the grant drops in the next cycle, even if the cycle-end and atomic lines would otherwise hold it.
- R8: Master 1 keeps its grant while its request is high, unless master 2 requests while master 1 reports a cycle end with its atomic line low.
- R9: Master 2, the highest priority, keeps its grant for as long as its request stays high. No other request preempts it.
- R10: If master 1 owns the bus with its request high, master 2 requests, `mst_cyc_end[1]` is high and `mst_atomic[1]` is low, all grants drop in the next cycle. Master 2 is granted in the cycle after that.
- R11: When master 1 or 2 owns the bus and drops its request, all grants drop in the next cycle.
- R12: An owner's atomic line high blocks every handover from that owner, even when its cycle-end line is high. The only exception is the processor while asleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mst_req | input | N_MST-1 | Bus requests of masters 1..N_MST-1. Bit k belongs to master k+1. |
| mst_cyc_end | input | N_MST | Per master: the current bus cycle ends in this clock |
| mst_atomic | input | N_MST | Per master: an indivisible multi-part access is in progress |
| cpu_sleep | input | 1 | The processor is in sleep mode |
| mst_gnt | output | N_MST | One-hot grant, registered. Bit 0 is the processor. |

## Verification
Some properties hold cycle by cycle, and the assertions check them on every cycle. These are: no more than one grant at a time, the dead cycle between owners, the choice of winner after a dead cycle, and the hold conditions for each owner. Sleep handover, preemption and release are also checked every cycle. Whole sequences only show up in the bench scenarios. Examples are a preempted transfer whose bus goes to the DMA engine two cycles later, and a deferred handover that completes once the atomic access finishes. The bench scenarios also show that the DMA engine keeps the bus through a long burst while the lower-priority master keeps requesting.

// File: rtl/bus_arb3_pkg.sv
package bus_arb3_pkg;
  // Phase of the grant register: an owner holds the bus, or the bus is in
  // the dead cycle between two owners.
  typedef enum logic {
    PH_HOLD = 1'b0,
    PH_GAP  = 1'b1
  } arb_phase_e;
endpackage

// File: rtl/bus_arb3_pick.sv
// Fixed-priority picker: the highest index among the requesters wins.
// Bit 0 (the default master) is never a requester.
module bus_arb3_pick #(
  parameter int N_MST = 3,
  localparam int IW = $clog2(N_MST)
) (
  input  logic [N_MST-1:0] req_all,
  output logic             any_req,
  output logic [IW-1:0]    top_idx
);
  always_comb begin
    any_req = 1'b0;
    top_idx = '0;
    for (int i = 1; i < N_MST; i++) begin
      if (req_all[i]) begin
        any_req = 1'b1;
        top_idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/bus_arb3_switch.sv
// Decides whether the current owner leaves the bus in this cycle.
module bus_arb3_switch #(
  parameter int N_MST = 3,
  localparam int IW = $clog2(N_MST)
) (
  input  logic [IW-1:0]    owner,
  input  logic [N_MST-1:0] req_all,
  input  logic [N_MST-1:0] cyc_end,
  input  logic [N_MST-1:0] atomic,
  input  logic             sleep,
  input  logic             any_req,
  input  logic [IW-1:0]    top_idx,
  output logic             leave
);
  logic at_break;
  logic higher_wait;

  always_comb begin
    at_break    = cyc_end[owner] && !atomic[owner];
    higher_wait = any_req && (top_idx > owner);
    if (owner == '0) begin
      // Processor: hand over at a clean boundary, or at once when asleep.
      leave = any_req && (sleep || at_break);
    end else begin
      // Requesting master: release when done, yield only to a higher one.
      leave = !req_all[owner] || (higher_wait && at_break);
    end
  end
endmodule

// File: rtl/bus_arb3_gnt.sv
// Grant register with a dead cycle between owners.
module bus_arb3_gnt
  import bus_arb3_pkg::*;
#(
  parameter int N_MST = 3,
  localparam int IW = $clog2(N_MST)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             leave,
  input  logic             any_req,
  input  logic [IW-1:0]    top_idx,
  output logic [IW-1:0]    owner,
  output logic [N_MST-1:0] gnt
);
  arb_phase_e       phase;
  logic [IW-1:0]    next_owner;
  logic [N_MST-1:0] next_gnt;

  always_comb begin
    next_owner           = any_req ? top_idx : '0;
    next_gnt             = '0;
    next_gnt[next_owner] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_HOLD;
      owner <= '0;
      gnt   <= N_MST'(1);
    end else begin
      case (phase)
        PH_HOLD: begin
          if (leave) begin
            phase <= PH_GAP;
            gnt   <= '0;
          end
        end
        default: begin
          phase <= PH_HOLD;
          owner <= next_owner;
          gnt   <= next_gnt;
        end
      endcase
    end
  end
endmodule

// File: rtl/bus_arb3.sv
module bus_arb3 #(
  parameter int N_MST = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_MST-2:0] mst_req,
  input  logic [N_MST-1:0] mst_cyc_end,
  input  logic [N_MST-1:0] mst_atomic,
  input  logic             cpu_sleep,
  output logic [N_MST-1:0] mst_gnt
);
  localparam int IW = $clog2(N_MST);

  logic [N_MST-1:0] req_all;
  logic             any_req;
  logic [IW-1:0]    top_idx;
  logic [IW-1:0]    owner;
  logic             leave;

  assign req_all = {mst_req, 1'b0};

  bus_arb3_pick #(.N_MST(N_MST)) pick_i (
    .req_all (req_all),
    .any_req (any_req),
    .top_idx (top_idx)
  );

  bus_arb3_switch #(.N_MST(N_MST)) sw_i (
    .owner   (owner),
    .req_all (req_all),
    .cyc_end (mst_cyc_end),
    .atomic  (mst_atomic),
    .sleep   (cpu_sleep),
    .any_req (any_req),
    .top_idx (top_idx),
    .leave   (leave)
  );

  bus_arb3_gnt #(.N_MST(N_MST)) gnt_i (
    .clk     (clk),
    .rst     (rst),
    .leave   (leave),
    .any_req (any_req),
    .top_idx (top_idx),
    .owner   (owner),
    .gnt     (mst_gnt)
  );
endmodule

// File: rtl/bus_arb3_chk.sv
module bus_arb3_chk #(
  parameter int N_MST = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [N_MST-2:0] mst_req,
  input logic [N_MST-1:0] mst_cyc_end,
  input logic [N_MST-1:0] mst_atomic,
  input logic             cpu_sleep,
  input logic [N_MST-1:0] mst_gnt
);
  logic [N_MST-1:0] rq;
  assign rq = {mst_req, 1'b0};

  a_r1_reset_cpu: assert property (@(posedge clk)
    rst |=> mst_gnt == N_MST'(1));

  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mst_gnt));

  a_r3_dead_cycle: assert property (@(posedge clk) disable iff (rst)
    (|mst_gnt) |=> (mst_gnt == '0 || mst_gnt == $past(mst_gnt)));

  a_r4_default_cpu: assert property (@(posedge clk) disable iff (rst)
    (mst_gnt == '0 && mst_req == '0) |=> mst_gnt == N_MST'(1));

  a_r5_top_wins: assert property (@(posedge clk) disable iff (rst)
    (mst_gnt == '0 && mst_req[N_MST-2]) |=> mst_gnt[N_MST-1]);

  a_r6_cpu_hold: assert property (@(posedge clk) disable iff (rst)
    (mst_gnt[0] && !cpu_sleep && !(mst_cyc_end[0] && !mst_atomic[0]))
      |=> mst_gnt[0]);

  a_r7_sleep_go: assert property (@(posedge clk) disable iff (rst)
    (mst_gnt[0] && cpu_sleep && (|mst_req)) |=> mst_gnt == '0);

  a_r9_top_keeps: assert property (@(posedge clk) disable iff (rst)
    (mst_gnt[N_MST-1] && mst_req[N_MST-2]) |=> mst_gnt[N_MST-1]);

  a_r12_cpu_atomic: assert property (@(posedge clk) disable iff (rst)
    (mst_gnt[0] && mst_atomic[0] && !cpu_sleep) |=> mst_gnt[0]);

  for (genvar i = 1; i < N_MST; i++) begin : g_mst
    logic higher;
    assign higher = |(rq >> (i + 1));

    // R8: keep the bus while requesting, unless a clean yield is due.
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
      (mst_gnt[i] && rq[i] && !(higher && mst_cyc_end[i] && !mst_atomic[i]))
        |=> mst_gnt[i]);

    // R10: a clean boundary with a higher requester forces a yield.
    a_r10_yield: assert property (@(posedge clk) disable iff (rst)
      (mst_gnt[i] && rq[i] && higher && mst_cyc_end[i] && !mst_atomic[i])
        |=> mst_gnt == '0);

    a_r11_release: assert property (@(posedge clk) disable iff (rst)
      (mst_gnt[i] && !rq[i]) |=> mst_gnt == '0);

    a_r12_atomic: assert property (@(posedge clk) disable iff (rst)
      (mst_gnt[i] && rq[i] && mst_atomic[i]) |=> mst_gnt[i]);
  end
endmodule

bind bus_arb3 bus_arb3_chk #(.N_MST(N_MST)) chk_i (.*);

// File: tb/bus_arb3_tb_top.sv
`timescale 1ns/1ps
module bus_arb3_tb_top;
  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-2:0] mst_req = '0;
  logic [N-1:0] mst_cyc_end = '0;
  logic [N-1:0] mst_atomic = '0;
  logic         cpu_sleep = 1'b0;
  logic [N-1:0] mst_gnt;

  int n_chk  = 0;
  int n_fail = 0;
  int n_onehot_bad = 0;
  int n_gap_bad = 0;
  logic [N-1:0] prev_gnt = '0;
  bit mon_on = 1'b0;

  always #4 clk = ~clk;

  bus_arb3 #(.N_MST(N)) dut_i (.*);

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input logic [N-1:0] exp, input string tag);
    n_chk++;
    if (mst_gnt !== exp) begin
      n_fail++;
      $display("FAIL %s: mst_gnt=%b expected=%b", tag, mst_gnt, exp);
    end
  endtask

  task automatic idle_inputs();
    mst_req = '0; mst_cyc_end = '0; mst_atomic = '0; cpu_sleep = 1'b0;
  endtask

  // Monitor for R2 and R3 on every cycle, sampled at the falling edge.
  always @(negedge clk) begin
    if (mon_on) begin
      if (!$onehot0(mst_gnt)) n_onehot_bad++;
      if (prev_gnt != '0 && mst_gnt != '0 && mst_gnt != prev_gnt) n_gap_bad++;
    end
    prev_gnt = mst_gnt;
  end

  task automatic t_reset();
    rst = 1'b1; idle_inputs();
    tick(); tick();
    chk(3'b001, "R1 reset grant");
    rst = 1'b0;
    tick();
    chk(3'b001, "R4 idle default");
    mon_on = 1'b1;
  endtask

  task automatic t_xfer_basic();
    mst_req = 2'b01;
    tick(); chk(3'b001, "R6 cpu holds without boundary");
    mst_cyc_end[0] = 1'b1;
    tick(); chk(3'b000, "R3 dead cycle");
    mst_cyc_end[0] = 1'b0;
    tick(); chk(3'b010, "R5 xfer granted");
    mst_cyc_end[1] = 1'b1;
    tick(); chk(3'b010, "R8 xfer keeps");
    mst_req = 2'b00;
    tick(); chk(3'b000, "R11 release");
    idle_inputs();
    tick(); chk(3'b001, "R4 back to cpu");
  endtask

  task automatic t_cpu_atomic();
    mst_req = 2'b01; mst_cyc_end[0] = 1'b1; mst_atomic[0] = 1'b1;
    tick(); chk(3'b001, "R12 cpu atomic defers");
    tick(); chk(3'b001, "R12 cpu atomic still defers");
    mst_atomic[0] = 1'b0;
    tick(); chk(3'b000, "R6 handover after atomic");
    tick(); chk(3'b010, "R5 xfer after atomic");
    idle_inputs();
    tick(); chk(3'b000, "R11 release");
    tick(); chk(3'b001, "R4 back to cpu");
  endtask

  task automatic t_sleep_and_burst();
    mst_req = 2'b10; cpu_sleep = 1'b1; mst_atomic[0] = 1'b1;
    tick(); chk(3'b000, "R7 sleep immediate");
    cpu_sleep = 1'b0; mst_atomic[0] = 1'b0;
    tick(); chk(3'b100, "R5 dma granted");
    mst_req = 2'b11; mst_cyc_end = 3'b111;
    for (int k = 0; k < 5; k++) begin
      tick(); chk(3'b100, "R9 dma keeps through burst");
    end
    mst_req = 2'b01;
    tick(); chk(3'b000, "R11 dma release");
    tick(); chk(3'b010, "R5 xfer after dma");
  endtask

  task automatic t_preempt();
    // Master 1 owns the bus here.
    mst_cyc_end = '0;
    mst_req = 2'b11;
    tick(); chk(3'b010, "R8 no boundary no yield");
    mst_cyc_end[1] = 1'b1; mst_atomic[1] = 1'b1;
    tick(); chk(3'b010, "R12 xfer atomic defers");
    mst_atomic[1] = 1'b0;
    tick(); chk(3'b000, "R10 yield to dma");
    mst_cyc_end[1] = 1'b0;
    tick(); chk(3'b100, "R10 dma after yield");
    mst_req = 2'b01;
    tick(); chk(3'b000, "R11 dma release");
    tick(); chk(3'b010, "R5 xfer resumes");
    idle_inputs();
    tick(); tick(); chk(3'b001, "R4 back to cpu");
  endtask

  task automatic t_both_request();
    mst_req = 2'b11; mst_cyc_end[0] = 1'b1;
    tick(); chk(3'b000, "R6 cpu leaves at boundary");
    mst_cyc_end[0] = 1'b0;
    tick(); chk(3'b100, "R5 dma beats xfer");
    idle_inputs();
    tick(); chk(3'b000, "R11 release");
    tick(); chk(3'b001, "R4 back to cpu");
  endtask

  task automatic t_monitor();
    n_chk++;
    if (n_onehot_bad != 0) begin
      n_fail++;
      $display("FAIL R2 onehot: violations=%0d expected=0", n_onehot_bad);
    end
    n_chk++;
    if (n_gap_bad != 0) begin
      n_fail++;
      $display("FAIL R3 dead cycle: violations=%0d expected=0", n_gap_bad);
    end
  endtask

  initial begin
    t_reset();
    t_xfer_basic();
    t_cpu_atomic();
    t_sleep_and_burst();
    t_preempt();
    t_both_request();
    t_monitor();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule